// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block performs the stack-frame work of a subroutine call, a subroutine return and a software-interrupt entry. It runs as a multi-cycle state machine and uses a single 32-bit data memory port. A start strobe supplies the following operands:

- the operation
- the current stack pointer, frame pointer and PC
- the instruction length
- a target word, which is either the call target or the interrupt number
- the interrupt handler address

A call reserves one word that is never written, called the static-chain slot. It then pushes the return address and the caller's frame pointer below that slot. A return unwinds the frame starting at the frame pointer, not at the stack pointer.

The results are the new stack pointer, frame pointer and PC. They appear on registered outputs, and a one-cycle done pulse marks when they are valid. A software interrupt also reports a cause code and the interrupt number, which the surrounding core stores in its special registers.

Top module: `frame_seq`

## Requirements
- R1: While reset is held and after it is released, `sp_o`, `fp_o`, `pc_o`, `done`, `mem_req` and `trap_we` are all zero.
- R2: The `op` code selects the operation: 1 is return, 2 is software interrupt, and 0 or 3 is call.
- R3: A call writes two words. It first writes the return address at `sp_in - 8`, then writes `fp_in` at `sp_in - 12`. The word at `sp_in - 4` is never written.
- R4: The return address is `pc_in + ilen`. This is 6 for a call with a 32-bit absolute target and 2 for a register-indirect call.
- R5: When a call completes, `sp_o` and `fp_o` both equal `sp_in - 12`, and `pc_o` equals `tgt`.
- R6: A return first reads the word at `fp_in`, then reads the word at `fp_in + 4`. When it completes, `fp_o` holds the first word read, `pc_o` holds the second, and `sp_o` equals `fp_in + 12`.
- R7: A software interrupt whose number (`tgt`) is all ones builds the same frame as a call, with return address `pc_in + ilen`, and sets `pc_o` to `handler_in`.
- R8: Any software interrupt pulses `trap_we` together with `done`, with `trap_cause` = 3 and `trap_num` = `tgt`. If the number is not all ones, no memory access is made, `sp_o` and `fp_o` keep `sp_in` and `fp_in`, and `pc_o` is `pc_in + ilen`.
- R9: Only one memory access is outstanding at a time. `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until the cycle in which `mem_ack` is high, and that cycle completes the access.
- R10: `done` is high for exactly one cycle, in the cycle after the last result update. A `start` seen while an operation is in progress, including the done cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | Operation code (see R2) |
| sp_in | input | 32 | Current stack pointer |
| fp_in | input | 32 | Current frame pointer |
| pc_in | input | 32 | PC of the instruction |
| ilen | input | 3 | Instruction length in bytes |
| tgt | input | 32 | Call target, or software-interrupt number |
| handler_in | input | 32 | Interrupt handler address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| sp_o | output | 32 | Resulting stack pointer |
| fp_o | output | 32 | Resulting frame pointer |
| pc_o | output | 32 | Resulting PC |
| done | output | 1 | One-cycle completion pulse |
| trap_we | output | 1 | Software-interrupt record strobe |
| trap_cause | output | 8 | Cause code (3) |
| trap_num | output | 32 | Software-interrupt number |

## Verification
A new `start` can arrive in the same cycle as an internal memory step, or in the same cycle as the done pulse.

The bench raises `start` with a different operation in both places:

- in the middle of a call, between its two writes;
- exactly in the cycle in which `done` is seen high.

It then judges the outcome in two ways. The first call's results must match the unperturbed expectation, with exactly two writes. Afterwards, no further memory request and no second done pulse may appear.

// File: rtl/frame_seq.sv
module frame_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [31:0] sp_in,
  input  logic [31:0] fp_in,
  input  logic [31:0] pc_in,
  input  logic [2:0]  ilen,
  input  logic [31:0] tgt,
  input  logic [31:0] handler_in,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic [31:0] sp_o,
  output logic [31:0] fp_o,
  output logic [31:0] pc_o,
  output logic        done,
  output logic        trap_we,
  output logic [7:0]  trap_cause,
  output logic [31:0] trap_num
);
  typedef enum logic [2:0] {S_IDLE, S_WRA, S_WFP, S_RFP, S_RRA, S_DONE} st_t;
  st_t st;
  logic [1:0]  op_r;
  logic [31:0] addr_r, wdata_r, fpsave_r, newpc_r;

  wire is_ret = (op == 2'd1);
  wire is_swi = (op == 2'd2);
  wire full_vec = &tgt;
  wire [31:0] ret_addr = pc_in + {29'd0, ilen};

  assign mem_req    = (st == S_WRA) || (st == S_WFP) || (st == S_RFP) || (st == S_RRA);
  assign mem_we     = (st == S_WRA) || (st == S_WFP);
  assign mem_addr   = addr_r;
  assign mem_wdata  = wdata_r;
  assign done       = (st == S_DONE);
  assign trap_we    = done && (op_r == 2'd2);
  assign trap_cause = 8'd3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_r     <= 2'd0;
      addr_r   <= '0;
      wdata_r  <= '0;
      fpsave_r <= '0;
      newpc_r  <= '0;
      sp_o     <= '0;
      fp_o     <= '0;
      pc_o     <= '0;
      trap_num <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_r <= op;
          if (is_swi) trap_num <= tgt;
          if (is_ret) begin
            addr_r <= fp_in;
            st     <= S_RFP;
          end else if (is_swi && !full_vec) begin
            sp_o <= sp_in;
            fp_o <= fp_in;
            pc_o <= ret_addr;
            st   <= S_DONE;
          end else begin
            addr_r   <= sp_in - 32'd8;
            wdata_r  <= ret_addr;
            fpsave_r <= fp_in;
            newpc_r  <= is_swi ? handler_in : tgt;
            st       <= S_WRA;
          end
        end
        S_WRA: if (mem_ack) begin
          addr_r  <= addr_r - 32'd4;
          wdata_r <= fpsave_r;
          st      <= S_WFP;
        end
        S_WFP: if (mem_ack) begin
          sp_o <= addr_r;
          fp_o <= addr_r;
          pc_o <= newpc_r;
          st   <= S_DONE;
        end
        S_RFP: if (mem_ack) begin
          fp_o   <= mem_rdata;
          sp_o   <= addr_r + 32'd12;
          addr_r <= addr_r + 32'd4;
          st     <= S_RRA;
        end
        S_RRA: if (mem_ack) begin
          pc_o <= mem_rdata;
          st   <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module frame_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        done,
  input logic        trap_we,
  input logic [31:0] sp_o,
  input logic [31:0] fp_o,
  input logic [1:0]  op_r
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
  // R5
  frame_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (op_r == 2'd0 || op_r == 2'd3) |-> sp_o == fp_o);
  // R8
  trap_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_we |-> done);
endmodule

bind frame_seq frame_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .trap_we(trap_we),
  .sp_o(sp_o), .fp_o(fp_o), .op_r(op_r)
);

// File: tb/frame_seq_tb.sv
module frame_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [31:0] sp_in = '0, fp_in = '0, pc_in = '0, tgt = '0;
  logic [31:0] handler_in = 32'h300;
  logic [2:0] ilen = 3'd0;
  logic mem_req, mem_we, mem_ack, done, trap_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, sp_o, fp_o, pc_o, trap_num;
  logic [7:0] trap_cause;

  always #4 clk = ~clk;

  frame_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sp_in(sp_in), .fp_in(fp_in),
    .pc_in(pc_in), .ilen(ilen), .tgt(tgt), .handler_in(handler_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .sp_o(sp_o), .fp_o(fp_o), .pc_o(pc_o),
    .done(done), .trap_we(trap_we), .trap_cause(trap_cause), .trap_num(trap_num)
  );

  logic [31:0] mem [64];
  int wcount = 0;
  logic [31:0] last_addr;
  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      for (int i = 0; i < 64; i++) mem[i] <= 32'hDEAD0000 | i;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack && mem_we) begin
        mem[mem_addr[7:2]] <= mem_wdata;
        wcount <= wcount + 1;
      end
    end
  end

  int nchk = 0, nerr = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R9 monitor: a pending request keeps its address until acknowledged
  always @(negedge clk) begin
    if (rst_n && mem_req && !mem_ack) last_addr <= mem_addr;
    if (rst_n && mem_req && mem_ack && $past(mem_req) && !$past(mem_ack))
      chk("R9 addr held", mem_addr, last_addr);
  end

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] sp, fp, pc;
    logic [2:0]  il;
    logic [31:0] tg, esp, efp, epc;
    logic [31:0] nw;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{2'd0, 32'h80, 32'h90, 32'h100, 3'd6, 32'h200, 32'h74, 32'h74, 32'h200, 32'd2},
    '{2'd1, 32'h74, 32'h74, 32'h200, 3'd2, 32'h0,   32'h80, 32'h90, 32'h106, 32'd0},
    '{2'd3, 32'hC0, 32'hD0, 32'h400, 3'd2, 32'h500, 32'hB4, 32'hB4, 32'h500, 32'd2},
    '{2'd1, 32'hB4, 32'hB4, 32'h500, 3'd2, 32'h0,   32'hC0, 32'hD0, 32'h402, 32'd0},
    '{2'd2, 32'hF0, 32'h10, 32'h600, 3'd6, 32'hFFFFFFFF, 32'hE4, 32'hE4, 32'h300, 32'd2},
    '{2'd2, 32'h40, 32'h50, 32'h700, 3'd6, 32'h5,   32'h40, 32'h50, 32'h706, 32'd0},
    '{2'd1, 32'hE4, 32'hE4, 32'h300, 3'd2, 32'h0,   32'hF0, 32'h10, 32'h606, 32'd0}
  };

  bit hung = 0;
  task automatic wait_done();
    int n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    if (!done) hung = 1;
  endtask

  task automatic issue(input vec_t v);
    op = v.op; sp_in = v.sp; fp_in = v.fp; pc_in = v.pc; ilen = v.il; tgt = v.tg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 req in reset", {31'd0, mem_req}, 32'd0);
    chk("R1 done in reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp", sp_o, 0);
    chk("R1 fp", fp_o, 0);
    chk("R1 pc", pc_o, 0);
    chk("R1 trap_we", {31'd0, trap_we}, 0);

    for (int k = 0; k < 7; k++) begin
      int w0;
      vec_t v;
      v = VEC[k];
      w0 = wcount;
      issue(v);
      wait_done();
      chk("R5/R6/R7/R8 sp", sp_o, v.esp);
      chk("R5/R6/R7/R8 fp", fp_o, v.efp);
      chk("R5/R6/R7/R8 pc", pc_o, v.epc);
      chk("R2/R3 write count", wcount - w0, v.nw);
      chk("R8 trap strobe", {31'd0, trap_we}, {31'd0, v.op == 2'd2});
      if (v.op == 2'd2) begin
        chk("R8 cause", {24'd0, trap_cause}, 32'd3);
        chk("R8 number", trap_num, v.tg);
      end
      @(negedge clk);
      chk("R10 done one cycle", {31'd0, done}, 0);
      if (v.nw == 32'd2) begin
        // R3 frame layout, R4 return address
        chk("R4 return addr", mem[(v.sp - 32'd8) >> 2], v.pc + {29'd0, v.il});
        chk("R3 saved fp", mem[(v.sp - 32'd12) >> 2], v.fp);
        chk("R3 static slot untouched", mem[(v.sp - 32'd4) >> 2], 32'hDEAD0000 | ((v.sp - 32'd4) >> 2));
      end
    end

    // R10: start in mid-call is ignored
    begin
      int w0;
      w0 = wcount;
      issue('{2'd0, 32'h30, 32'h20, 32'h10, 3'd6, 32'h44, 32'h0, 32'h0, 32'h0, 32'h0});
      @(negedge clk);
      op = 2'd1; fp_in = 32'h74; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk("R10 busy start sp", sp_o, 32'h24);
      chk("R10 busy start fp", fp_o, 32'h24);
      chk("R10 busy start pc", pc_o, 32'h44);
      chk("R10 busy start writes", wcount - w0, 2);
      repeat (6) begin
        @(negedge clk);
        chk("R10 no stray req", {31'd0, mem_req | done}, 0);
      end
    end

    // R10: start during the done cycle is ignored
    issue('{2'd2, 32'h40, 32'h50, 32'h800, 3'd6, 32'h9, 32'h0, 32'h0, 32'h0, 32'h0});
    wait_done();
    chk("R8 short swi pc", pc_o, 32'h806);
    op = 2'd0; sp_in = 32'hA0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) begin
      chk("R10 done-cycle start", {31'd0, mem_req | done}, 0);
      @(negedge clk);
    end
    chk("R10 results kept", sp_o, 32'h40);

    if (hung) begin
      nerr++;
      $display("FAIL R10 done never seen: actual 0 expected 1");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule